// File: doc/BRIEF.md
# Register-Driven SPI Command Engine

This block is a small SPI master that a host drives through eight byte-wide registers on a simple synchronous register bus. The host first stores an opcode, up to three address bytes and an optional trailing data byte in the data registers. It then writes a control byte. That byte chooses the serial clock rate, the number of bytes to send and the number of bytes to read back. The engine lowers chip select and shifts out 1, 2, 4 or 5 bytes. It then shifts in up to 3 response bytes and writes them into the upper registers, where the host reads them.

While a command is on the wire, the top bit of the control register reads as 1. The host polls that bit before it reads the results or issues the next command. A control write that arrives during a transfer is dropped. The two serial clock rates are set as half-periods, counted in system clock cycles.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high (inactive), SCLK is low, and every register from offset 0 to offset 7 reads as 0x00.
- R2: A write to offset 0 starts a command only when bits [6:4] equal 4 (slow clock) or 5 (fast clock) and the engine is idle. Any other value in [6:4] starts nothing and leaves the offset-0 readback unchanged. Bits [6:0] of the last accepted control byte read back at offset 0.
- R3: Bit 7 of offset 0 reads as 1 from the cycle after an accepted control write until chip select has returned high.
- R4: Control bits [1:0] set the number of bytes sent: code 0 sends 1 byte, code 1 sends 2, code 2 sends 4 and code 3 sends 5.
- R5: The opcode at offset 1 is always sent first. In 4-byte and 5-byte commands, offsets 4, 3 and 2 follow in that order. The byte at offset 7 is sent second in a 2-byte command and last in a 5-byte command.
- R6: Control bits [3:2] give a response length of 0 to 3 bytes. The received bytes are stored at offsets 5, 6 and 7 in arrival order, and the registers beyond that length keep their previous contents. MOSI is low while the response is clocked in.
- R7: Data uses SPI mode 0, MSB first. SCLK is low whenever chip select is high. Chip select falls at least one cycle before the first SCLK rise and rises only after the last SCLK fall. MOSI changes only on a falling SCLK edge or when a command starts.
- R8: SCLK high and low phases each last FAST_HALF system cycles at the fast rate and SLOW_HALF cycles at the slow rate.
- R9: A control write made while bit 7 of offset 0 is 1 has no effect: no second transfer follows, and the offset-0 readback keeps its value.
- R10: Offsets 1 to 7 can be written and read back by the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Register offset for reads and writes |
| host_we | input | 1 | Write strobe for one cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The hardest case to reach from the ports is a control write that lands inside a running transfer. The bench starts a long command: five bytes out and three back at the slow rate. A few cycles later, while the busy bit still reads 1, it writes a different start code. It then checks that exactly one transfer appears on the wire and that the readback still holds the first control byte. A bench slave model answers on MISO on every falling SCLK edge. This lets the response bytes be checked against the offsets they are stored in, including the case where a three-byte response overwrites the trailing data byte at offset 7.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   typedef logic [7:0] byte_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LEAD,
      ST_SHIFT,
      ST_TRAIL
   } seq_st_e;

   localparam logic [2:0] GO_SLOW = 3'd4;
   localparam logic [2:0] GO_FAST = 3'd5;

   // send-length code to byte count
   function automatic logic [2:0] send_len(input logic [1:0] code);
      case (code)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         2'd2:    return 3'd4;
         default: return 3'd5;
      endcase
   endfunction
endpackage

// File: rtl/spi_cmd_clkdiv.sv
module spi_cmd_clkdiv #(
   parameter int FAST_HALF = 1,
   parameter int SLOW_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic fast,
   output logic tick
);
   localparam int CNT_W = (SLOW_HALF > 1) ? $clog2(SLOW_HALF) : 1;

   generate
      if (SLOW_HALF == 1) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         logic [CNT_W-1:0] cnt;
         logic [CNT_W-1:0] limit;
         assign limit = fast ? CNT_W'(FAST_HALF - 1) : CNT_W'(SLOW_HALF - 1);
         assign tick  = run && (cnt >= limit);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (!run)       cnt <= '0;
            else if (cnt >= limit) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
   import spi_cmd_pkg::*;
#(
   parameter int NREG = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_we,
   input  logic [2:0]          host_addr,
   input  byte_t               host_wdata,
   input  logic                rx_we,
   input  logic [1:0]          rx_idx,
   input  byte_t               rx_data,
   input  byte_t               ctrl_view,
   output byte_t               rdata,
   output logic [NREG-1:1][7:0] store
);
   localparam int RX_BASE = 5;

   generate
      for (genvar i = 1; i < NREG; i++) begin : g_reg
         logic rx_hit;
         assign rx_hit = rx_we && (i >= RX_BASE) && (32'(rx_idx) == i - RX_BASE);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                     store[i] <= '0;
            else if (rx_hit)                                store[i] <= rx_data;
            else if (host_we && (32'(host_addr) == i))      store[i] <= host_wdata;
         end
      end
   endgenerate

   always_comb begin
      if (host_addr == 3'd0) rdata = ctrl_view;
      else                   rdata = store[host_addr];
   end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
   import spi_cmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       fast_in,
   input  logic [1:0] wr_code,
   input  logic [1:0] rd_cnt,
   input  byte_t      op_b,
   input  byte_t      adr_hi,
   input  byte_t      adr_mid,
   input  byte_t      adr_lo,
   input  byte_t      tail_b,
   input  logic       tick,
   input  logic       miso,
   output logic       busy,
   output logic       fast_q,
   output logic       sclk,
   output logic       cs_n,
   output logic       mosi,
   output logic       rx_we,
   output logic [1:0] rx_idx,
   output byte_t      rx_data
);
   seq_st_e          st;
   logic [7:0][7:0]  txb;
   logic [7:0][7:0]  txb_nx;
   logic [5:0]       bitcnt, last_bit;
   logic [2:0]       wrn;
   byte_t            shreg, rxsh;
   logic [2:0]       byte_idx, nidx;
   logic [3:0]       total;

   assign busy     = (st != ST_IDLE);
   assign mosi     = shreg[7];
   assign byte_idx = bitcnt[5:3];
   assign nidx     = byte_idx + 3'd1;
   assign total    = {1'b0, send_len(wr_code)} + {2'b00, rd_cnt};

   // wire order of the outgoing bytes, zero filled
   always_comb begin
      txb_nx    = '0;
      txb_nx[0] = op_b;
      case (wr_code)
         2'd1: txb_nx[1] = tail_b;
         2'd2: begin
            txb_nx[1] = adr_hi; txb_nx[2] = adr_mid; txb_nx[3] = adr_lo;
         end
         2'd3: begin
            txb_nx[1] = adr_hi; txb_nx[2] = adr_mid; txb_nx[3] = adr_lo;
            txb_nx[4] = tail_b;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; txb <= '0; bitcnt <= '0; last_bit <= '0; wrn <= '0;
         shreg <= '0; rxsh <= '0; sclk <= 1'b0; cs_n <= 1'b1; fast_q <= 1'b0;
         rx_we <= 1'b0; rx_idx <= '0; rx_data <= '0;
      end else begin
         rx_we <= 1'b0;
         case (st)
            ST_IDLE: if (start) begin
               txb      <= txb_nx;
               shreg    <= op_b;
               bitcnt   <= '0;
               last_bit <= {total[2:0], 3'b000} - 6'd1;
               wrn      <= send_len(wr_code);
               fast_q   <= fast_in;
               cs_n     <= 1'b0;
               sclk     <= 1'b0;
               st       <= ST_LEAD;
            end
            ST_LEAD: if (tick) st <= ST_SHIFT;
            ST_SHIFT: if (tick) begin
               if (!sclk) begin
                  sclk <= 1'b1;
                  rxsh <= {rxsh[6:0], miso};
               end else begin
                  sclk <= 1'b0;
                  if (bitcnt[2:0] == 3'd7 && byte_idx >= wrn) begin
                     rx_we   <= 1'b1;
                     rx_idx  <= 2'(byte_idx - wrn);
                     rx_data <= rxsh;
                  end
                  if (bitcnt == last_bit) begin
                     st <= ST_TRAIL;
                  end else begin
                     bitcnt <= bitcnt + 6'd1;
                     shreg  <= (bitcnt[2:0] == 3'd7) ? txb[nidx] : {shreg[6:0], 1'b0};
                  end
               end
            end
            ST_TRAIL: if (tick) begin
               cs_n <= 1'b1;
               st   <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
   import spi_cmd_pkg::*;
#(
   parameter int FAST_HALF = 1,
   parameter int SLOW_HALF = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] host_addr,
   input  logic       host_we,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   output logic       spi_sclk,
   output logic       spi_cs_n,
   output logic       spi_mosi,
   input  logic       spi_miso
);
   localparam int NREG = 8;

   generate
      if (FAST_HALF < 1 || SLOW_HALF < FAST_HALF) begin : g_bad_div
         $error("spi_cmd_engine: need 1 <= FAST_HALF <= SLOW_HALF");
      end
   endgenerate

   logic                busy, fast_q, tick, start, ctrl_hit;
   logic                rx_we;
   logic [1:0]          rx_idx;
   byte_t               rx_data, ctrl_q, ctrl_view;
   logic [NREG-1:1][7:0] store;

   assign ctrl_hit  = host_we && (host_addr == 3'd0);
   assign start     = ctrl_hit && !busy &&
                      (host_wdata[6:4] == GO_SLOW || host_wdata[6:4] == GO_FAST);
   assign ctrl_view = {busy, ctrl_q[6:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= '0;
      else if (start) ctrl_q <= host_wdata;
   end

   spi_cmd_regs #(.NREG(NREG)) u_regs (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .rx_we(rx_we), .rx_idx(rx_idx), .rx_data(rx_data),
      .ctrl_view(ctrl_view), .rdata(host_rdata), .store(store)
   );

   spi_cmd_clkdiv #(.FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .fast(fast_q), .tick(tick)
   );

   spi_cmd_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .fast_in(host_wdata[4]),
      .wr_code(host_wdata[1:0]), .rd_cnt(host_wdata[3:2]),
      .op_b(store[1]), .adr_hi(store[4]), .adr_mid(store[3]), .adr_lo(store[2]),
      .tail_b(store[7]), .tick(tick), .miso(spi_miso), .busy(busy),
      .fast_q(fast_q), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
      .rx_we(rx_we), .rx_idx(rx_idx), .rx_data(rx_data)
   );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sclk,
   input logic       cs_n,
   input logic       mosi,
   input logic       busy,
   input logic       host_we,
   input logic [2:0] host_addr,
   input logic [7:0] ctrl_q
);
   // R7: clock idles low outside a transfer
   p_idle_sclk_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R7: lead-in gap between chip select falling and first clock rise
   p_cs_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |=> !sclk);

   // R7: MOSI moves only on a falling clock edge inside a transfer
   p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n) && !$fell(sclk)) |-> $stable(mosi));

   // R3: chip select low implies the busy flag is set
   p_busy_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);

   // R9: control writes while busy leave the control register alone
   p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && host_we && host_addr == 3'd0) |=> $stable(ctrl_q));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
   .busy(busy), .host_we(host_we), .host_addr(host_addr), .ctrl_q(ctrl_q)
);

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;
   localparam int FAST_HALF = 1;
   localparam int SLOW_HALF = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] host_addr = '0;
   logic       host_we = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       spi_sclk, spi_cs_n, spi_mosi;
   logic       spi_miso = 1'b0;

   always #2 clk = ~clk;

   spi_cmd_engine #(.FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) u_spi_cmd_engine (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .spi_sclk(spi_sclk),
      .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   // scoreboard queues
   logic [63:0] q_bits[$];
   int          q_nbits[$];
   int          q_half[$];
   logic [7:0]  mdl [8];

   // slave model
   logic [63:0] slave_resp = '0;
   int          slv_i = 0;
   logic [63:0] cap;
   int          ncap;
   time         t_r1, t_r2;

   always @(negedge spi_cs_n) begin
      slv_i = 0; cap = '0; ncap = 0;
      spi_miso = slave_resp[63];
      chk("R7 sclk low at cs fall", spi_sclk, 1'b0);
   end
   always @(negedge spi_sclk) if (!spi_cs_n) begin
      slv_i++;
      spi_miso = (slv_i < 64) ? slave_resp[63 - slv_i] : 1'b0;
   end
   always @(posedge spi_sclk) begin
      cap = {cap[62:0], spi_mosi};
      ncap++;
      if (ncap == 1) t_r1 = $time;
      if (ncap == 2) t_r2 = $time;
   end
   // monitor: compare a finished transfer with the next expected item
   always @(posedge spi_cs_n) if (rst_n) begin
      chk("R7 sclk low at cs rise", spi_sclk, 1'b0);
      if (q_bits.size() == 0) begin
         n_chk++; n_fail++;
         $display("FAIL R9: unexpected transfer got %0d bits expected none", ncap);
      end else begin
         logic [63:0] eb; int en, eh;
         eb = q_bits.pop_front(); en = q_nbits.pop_front(); eh = q_half.pop_front();
         chk("R4 bit count", 64'(ncap), 64'(en));
         chk("R5 R6 mosi stream", cap, eb);
         chk("R8 half period", 64'((t_r2 - t_r1) / 8), 64'(eh));
      end
   end

   task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); host_addr = a; host_wdata = d; host_we = 1'b1;
      @(negedge clk); host_we = 1'b0;
   endtask

   task automatic hread(input logic [2:0] a, output logic [7:0] d);
      host_addr = a; #1; d = host_rdata;
   endtask

   task automatic wait_idle();
      logic [7:0] v;
      do begin @(negedge clk); hread(3'd0, v); end while (v[7]);
   endtask

   // driver: set registers, push expectation, start
   task automatic run_cmd(input bit fast, input logic [1:0] wc, input int rd,
                          input logic [7:0] op, input logic [7:0] a4, input logic [7:0] a3,
                          input logic [7:0] a2, input logic [7:0] t7,
                          input logic [7:0] s0, input logic [7:0] s1, input logic [7:0] s2);
      logic [7:0] wb[5]; logic [7:0] sr[3]; int wn; logic [63:0] eb, rs; logic [7:0] v;
      hwrite(3'd1, op); hwrite(3'd4, a4); hwrite(3'd3, a3); hwrite(3'd2, a2); hwrite(3'd7, t7);
      mdl[1] = op; mdl[4] = a4; mdl[3] = a3; mdl[2] = a2; mdl[7] = t7;
      sr[0] = s0; sr[1] = s1; sr[2] = s2;
      case (wc)
         2'd0: begin wn = 1; wb[0] = op; end
         2'd1: begin wn = 2; wb[0] = op; wb[1] = t7; end
         2'd2: begin wn = 4; wb[0] = op; wb[1] = a4; wb[2] = a3; wb[3] = a2; end
         default: begin wn = 5; wb[0] = op; wb[1] = a4; wb[2] = a3; wb[3] = a2; wb[4] = t7; end
      endcase
      eb = '0;
      for (int i = 0; i < wn + rd; i++) eb = {eb[55:0], (i < wn) ? wb[i] : 8'h00};
      rs = '0;
      for (int i = 0; i < 8; i++) rs = {rs[55:0], (i >= wn && i < wn + rd) ? sr[i - wn] : 8'h00};
      slave_resp = rs;
      q_bits.push_back(eb); q_nbits.push_back(8 * (wn + rd));
      q_half.push_back(fast ? FAST_HALF : SLOW_HALF);
      hwrite(3'd0, {1'b0, 2'b10, fast, 2'(rd), wc});
      hread(3'd0, v);
      chk("R3 busy set", v[7], 1'b1);
      chk("R2 ctrl readback", v[6:0], {2'b10, fast, 2'(rd), wc});
      wait_idle();
      chk("R3 cs high when idle", spi_cs_n, 1'b1);
      for (int k = 0; k < rd; k++) mdl[5 + k] = sr[k];
      for (int k = 5; k < 8; k++) begin
         hread(3'(k), v);
         chk("R6 rx register", v, mdl[k]);
      end
   endtask

   initial begin
      logic [7:0] v;
      for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         hread(3'(i), v);
         chk("R1 reset register", v, 8'h00);
      end
      chk("R1 cs idle", spi_cs_n, 1'b1);
      chk("R1 sclk idle", spi_sclk, 1'b0);
      rst_n = 1'b1;
      // R10 storage
      for (int i = 1; i < 8; i++) hwrite(3'(i), 8'h10 + 8'(i * 17));
      for (int i = 1; i < 8; i++) begin
         mdl[i] = 8'h10 + 8'(i * 17);
         hread(3'(i), v);
         chk("R10 readback", v, mdl[i]);
      end
      // R4 R5 R6 R8: shapes and speeds
      run_cmd(1, 2'd0, 0, 8'h9F, 8'h00, 8'h00, 8'h00, 8'h33, 8'h00, 8'h00, 8'h00);
      run_cmd(1, 2'd0, 3, 8'h9F, 8'h01, 8'h02, 8'h03, 8'h44, 8'hC2, 8'h20, 8'h17);
      run_cmd(0, 2'd1, 1, 8'h01, 8'hAA, 8'hBB, 8'hCC, 8'h5A, 8'h81, 8'h00, 8'h00);
      run_cmd(1, 2'd2, 2, 8'h03, 8'h12, 8'h34, 8'h56, 8'h77, 8'hDE, 8'hAD, 8'h00);
      run_cmd(0, 2'd3, 0, 8'h02, 8'h0F, 8'hF0, 8'h3C, 8'hE7, 8'h00, 8'h00, 8'h00);
      // R2: non-start code in [6:4] does nothing
      hread(3'd0, v);
      hwrite(3'd0, 8'h33);
      repeat (20) @(negedge clk);
      begin
         logic [7:0] v2;
         hread(3'd0, v2);
         chk("R2 non-start readback", v2, {1'b0, v[6:0]});
         chk("R2 non-start cs", spi_cs_n, 1'b1);
      end
      // R9: control write during a slow 5+3 transfer
      slave_resp = '0;
      begin
         logic [7:0] t;
         hwrite(3'd1, 8'h0B); hwrite(3'd4, 8'h01); hwrite(3'd3, 8'h02);
         hwrite(3'd2, 8'h03); hwrite(3'd7, 8'h04);
         slave_resp = {40'h0, 8'h11, 8'h22, 8'h33};
         q_bits.push_back({8'h0B, 8'h01, 8'h02, 8'h03, 8'h04, 24'h0});
         q_nbits.push_back(64); q_half.push_back(SLOW_HALF);
         hwrite(3'd0, 8'h4F);
         repeat (5) @(negedge clk);
         hwrite(3'd0, 8'h51);
         hread(3'd0, t);
         chk("R9 busy during ignore", t[7], 1'b1);
         chk("R9 readback kept", t[6:0], 7'h4F);
         wait_idle();
         hread(3'd0, t);
         chk("R9 readback after", t, 8'h4F);
         hread(3'd7, t);
         chk("R6 third byte over offset 7", t, 8'h33);
         repeat (40) @(negedge clk);
         chk("R9 no second transfer", spi_cs_n, 1'b1);
      end
      chk("R4 scoreboard drained", 64'(q_bits.size()), 64'd0);
      done = 1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (150000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule